// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous burst memory. A burst starts when either of two address strobes is high at a rising clock edge. One strobe comes from a processor and the other from a cache controller. The external address is then captured and driven out unchanged. Later beats of the burst are generated inside the block. A two-bit beat counter moves forward by one on each edge where the advance input is high. The upper address bits stay fixed for the whole burst.

A static order input selects how the beat count maps onto the two low address bits. A low level gives linear stepping: the loaded low bits plus the beat count, modulo four. A high level gives interleaved stepping: the loaded low bits XOR the beat count. A flag marks the first beat of each burst, meaning the address that was just loaded. Both outputs are registered. Every input is sampled on the rising edge of the single clock.

Top module: `bseq_addr_gen`

## Requirements
- R1: While the synchronous active-high reset is high at a clock edge, the address output becomes 0 and the first-beat flag becomes 0 after that edge.
- R2: When either strobe is high at an edge, the address output equals the external address after that edge and the first-beat flag is 1.
- R3: When both strobes are high together, one load takes place and the processor strobe has priority. The advance input is ignored at any edge where a strobe loads.
- R4: With the order input low (linear), each advance sets the low two address bits to (loaded low bits + beat count) mod 4.
- R5: With the order input high (interleaved), each advance sets the low two address bits to (loaded low bits XOR beat count).
- R6: After four advances the low bits return to the loaded value. No carry or borrow ever reaches the upper address bits between loads.
- R7: When neither strobe nor advance is high, the address output and the first-beat flag keep their values. This holds even if the order input changes.
- R8: The first-beat flag clears after the first advance of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| strb_cpu | input | 1 | Processor address strobe (priority) |
| strb_ctl | input | 1 | Cache-controller address strobe |
| adv | input | 1 | Burst advance |
| ord_il | input | 1 | Order select: 0 linear, 1 interleaved |
| ext_addr | input | ADDR_W | External start address |
| addr_q | output | ADDR_W | Registered current word address |
| first_beat | output | 1 | High while the output is the burst's loaded address |

## Verification
On every cycle, assertions check the following. A load lands the external address and zeroes the beat counter. An advance without a load raises the counter by exactly one. The upper bits never change except on a load. An idle cycle freezes the output. The actual lane values are checked only by the bench scenarios, because they depend on the order input and the loaded low bits. These scenarios cover the linear and interleaved sequences, wrap after four beats, both strobes together, and an advance applied on a load cycle.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int CNT_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_cnt.sv
module burst_cnt
  import bseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             first_q
);
  always_comb begin
    if (load)     cnt_nxt = '0;
    else if (adv) cnt_nxt = cnt_q + CNT_W'(1);
    else          cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (load)     first_q <= 1'b1;
      else if (adv) first_q <= 1'b0;
    end
  end

  AST_LOAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == '0) && first_q); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!load && adv) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)) && !first_q); // R8
endmodule

// File: rtl/burst_lane_map.sv
module burst_lane_map
  import bseq_pkg::*;
(
  input  logic [CNT_W-1:0] base_lo,
  input  logic [CNT_W-1:0] beat,
  input  logic             ord_il,
  output logic [CNT_W-1:0] lane
);
  logic [CNT_W-1:0] lane_lin;
  logic [CNT_W-1:0] lane_xor;

  assign lane_lin = base_lo + beat;
  assign lane_xor = base_lo ^ beat;

  always_comb begin
    unique case (order_e'(ord_il))
      ORD_LINEAR:     lane = lane_lin;
      ORD_INTERLEAVE: lane = lane_xor;
      default:        lane = lane_lin;
    endcase
  end
endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strb_cpu,
  input  logic              strb_ctl,
  input  logic              adv,
  input  logic              ord_il,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] addr_q,
  output logic              first_beat
);
  localparam int HI_W = ADDR_W - CNT_W;

  logic             load;
  logic [CNT_W-1:0] base_lo_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] lane;

  // processor strobe has priority; both request the same capture
  always_comb begin
    if (strb_cpu)      load = 1'b1;
    else if (strb_ctl) load = 1'b1;
    else               load = 1'b0;
  end

  burst_cnt u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .adv     (adv),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt),
    .first_q (first_beat)
  );

  burst_lane_map u_map (
    .base_lo (base_lo_q),
    .beat    (cnt_nxt),
    .ord_il  (ord_il),
    .lane    (lane)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_lo_q <= '0;
      addr_q    <= '0;
    end else if (load) begin
      base_lo_q <= ext_addr[CNT_W-1:0];
      addr_q    <= ext_addr;
    end else if (adv) begin
      addr_q    <= {addr_q[ADDR_W-1:CNT_W], lane};
    end
  end

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (rst)
    load |=> (addr_q == $past(ext_addr)) && first_beat); // R2
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    !load |=> addr_q[ADDR_W-1:CNT_W] == $past(addr_q[ADDR_W-1:CNT_W])); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> $stable(addr_q) && $stable(first_beat)); // R7
  AST_LOW_TRACK: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0) |-> (addr_q[CNT_W-1:0] == base_lo_q)); // R6

  initial begin
    AST_WIDTH_OK: assert (HI_W >= 1); // R6
  end
endmodule

// File: tb/bseq_addr_gen_bench.sv
module bseq_addr_gen_bench;
  localparam int AW    = 17;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic          cpu;
    logic          ctl;
    logic          adv;
    logic          ord;
    logic [AW-1:0] ext;
    logic [AW-1:0] exp_a;
    logic          exp_f;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0, 17'h0ABC1, 17'h0ABC1, 1'b1}, // R2 cpu load
    '{1'b0,1'b0,1'b1,1'b0, 17'h00000, 17'h0ABC2, 1'b0}, // R4 R8
    '{1'b0,1'b0,1'b1,1'b0, 17'h00000, 17'h0ABC3, 1'b0}, // R4
    '{1'b0,1'b0,1'b1,1'b0, 17'h00000, 17'h0ABC0, 1'b0}, // R6 no carry
    '{1'b0,1'b0,1'b1,1'b0, 17'h00000, 17'h0ABC1, 1'b0}, // R6 wrap
    '{1'b0,1'b0,1'b0,1'b1, 17'h00000, 17'h0ABC1, 1'b0}, // R7 hold, order flips
    '{1'b0,1'b1,1'b1,1'b1, 17'h1FFFE, 17'h1FFFE, 1'b1}, // R2 ctl load, R3 adv ignored
    '{1'b0,1'b0,1'b1,1'b1, 17'h00000, 17'h1FFFF, 1'b0}, // R5
    '{1'b0,1'b0,1'b1,1'b1, 17'h00000, 17'h1FFFC, 1'b0}, // R5 R6 no borrow
    '{1'b0,1'b0,1'b1,1'b1, 17'h00000, 17'h1FFFD, 1'b0}, // R5
    '{1'b0,1'b0,1'b1,1'b1, 17'h00000, 17'h1FFFE, 1'b0}, // R6 wrap
    '{1'b1,1'b1,1'b1,1'b1, 17'h00007, 17'h00007, 1'b1}, // R3 both strobes
    '{1'b0,1'b0,1'b0,1'b0, 17'h00000, 17'h00007, 1'b1}, // R7 flag held
    '{1'b0,1'b0,1'b1,1'b1, 17'h00000, 17'h00006, 1'b0}  // R5 R8
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          strb_cpu, strb_ctl, adv, ord_il;
  logic [AW-1:0] ext_addr;
  logic [AW-1:0] addr_q;
  logic          first_beat;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bseq_addr_gen #(.ADDR_W(AW)) u_bseq_addr_gen (
    .clk(clk), .rst(rst), .strb_cpu(strb_cpu), .strb_ctl(strb_ctl),
    .adv(adv), .ord_il(ord_il), .ext_addr(ext_addr),
    .addr_q(addr_q), .first_beat(first_beat)
  );

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic c, logic t, logic a, logic o, logic [AW-1:0] e);
    @(negedge clk);
    strb_cpu = c; strb_ctl = t; adv = a; ord_il = o; ext_addr = e;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 5000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1; strb_cpu = 0; strb_ctl = 0; adv = 0; ord_il = 0; ext_addr = '0;
    step(1'b0, 1'b0, 1'b0, 1'b0, 17'h1F0F0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 17'h1F0F0);
    check("R1 reset addr", addr_q, '0);
    check("R1 reset flag", AW'(first_beat), '0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].cpu, VEC[i].ctl, VEC[i].adv, VEC[i].ord, VEC[i].ext);
      check($sformatf("vector %0d addr (R2-R8 tags per row)", i), addr_q, VEC[i].exp_a);
      check($sformatf("vector %0d first_beat", i), AW'(first_beat), AW'(VEC[i].exp_f));
    end

    // R4: linear from low bits 10, long run with idle gaps
    step(1'b1, 1'b0, 1'b0, 1'b0, 17'h15556);
    for (int k = 1; k <= 6; k++) begin
      step(1'b0, 1'b0, 1'b0, 1'b0, 17'h0);
      check("R7 idle gap", addr_q, {15'h5555, 2'(2 + k - 1)});
      step(1'b0, 1'b0, 1'b1, 1'b0, 17'h0);
      check("R4 linear step", addr_q, {15'h5555, 2'(2 + k)});
    end

    // R3: adv held across a reload restarts at beat 0
    step(1'b1, 1'b0, 1'b1, 1'b0, 17'h0A001);
    check("R3 reload with adv", addr_q, 17'h0A001);
    check("R3 reload flag", AW'(first_beat), AW'(1));

    // R1: reset in mid-burst
    step(1'b0, 1'b0, 1'b1, 1'b0, 17'h0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 mid-run reset addr", addr_q, '0);
    check("R1 mid-run reset flag", AW'(first_beat), '0);
    finish_run();
  end
endmodule